// File: doc/BRIEF.md
# X-Y Mesh Path Reservation Unit

This unit decides whether a transfer may cross a two-dimensional on-chip mesh that links cache banks to cores. A request gives a source node, a target node and a tag. The unit works out the dimension-ordered route for that request. The route first moves along X until it reaches the target column, then moves along Y until it reaches the target row. If every directional link on that route is free, the unit reserves all of them at once and answers with a grant and the hop count. If any link on the route is busy, it answers with a refusal and leaves every link as it was. The requester then decides whether to retry the same request later or to issue a different one.

A release port takes a source and target pair and frees the links of that pair's route. A release and a request may arrive in the same cycle. In that case the release is applied first, so the request can use links that the release has just freed. The unit handles at most one request and one release per cycle. The actual data movement and the timing of retries belong to the requester.

Top module: `meshPathReserve`

## Requirements
- R1: After reset every link is free, and respValid and relError are low.
- R2: A route from (sx,sy) to (dx,dy) uses the links along row sy between columns sx and dx, and then the links along column dx between rows sy and dy. No other link is on the route.
- R3: When a request is presented in cycle N and every link on its route is free, the response in cycle N+1 has respValid=1 and respGrant=1. From that cycle on, every link on the route is marked occupied.
- R4: When any link on a request's route is occupied, the response in cycle N+1 has respGrant=0 and respHops=0. No link changes because of that request.
- R5: A request whose source equals its target is granted with respHops=0 and reserves no link.
- R6: With a grant, respHops equals |dx-sx|+|dy-sy|, which is the number of links reserved.
- R7: A release frees exactly the links on the route of its source and target. relError is 1 in the next cycle if at least one of those links was not occupied.
- R8: A release and a request in the same cycle are handled release first, so the request sees the links that the release freed.
- R9: Links are directional. A link from node a to node b and the link from b to a are reserved independently.
- R10: Each request gets exactly one response, one cycle later. That response echoes the request's tag in respTag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqSrcX | input | XW | Request source column |
| reqSrcY | input | YW | Request source row |
| reqDstX | input | XW | Request target column |
| reqDstY | input | YW | Request target row |
| reqTag | input | TAG_W | Tag echoed with the response |
| relValid | input | 1 | Release strobe |
| relSrcX | input | XW | Release source column |
| relSrcY | input | YW | Release source row |
| relDstX | input | XW | Release target column |
| relDstY | input | YW | Release target row |
| respValid | output | 1 | Response present |
| respGrant | output | 1 | 1 = path reserved, 0 = refused |
| respTag | output | TAG_W | Tag of the request being answered |
| respHops | output | HW | Hop count of a granted path, 0 otherwise |
| relError | output | 1 | The last release found a link that was not reserved |

## Verification
Every result of this block appears one register stage after its stimulus. The response to a request in cycle N, the error flag of a release in cycle N, and the occupancy change that a later request will see are all visible after the clock edge that closes cycle N. The bench drives a request and a release, computes the expected response from its own per-direction link model, and samples one time unit after that edge. Link occupancy has no output of its own, so the bench infers it through later requests and releases. A refused request and a same-cycle release are each followed by a request whose outcome depends on exactly the links in question.

// File: rtl/meshPkg.sv
package meshPkg;
  typedef struct packed {
    logic doGrant;
    logic doRelease;
  } ctlStrobe_t;
endpackage

// File: rtl/xyRouteMask.sv
module xyRouteMask #(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int XW = $clog2(MESH_X),
  parameter int YW = $clog2(MESH_Y),
  parameter int HW = $clog2(MESH_X + MESH_Y - 1),
  parameter int NLINK = 2 * MESH_Y * (MESH_X - 1) + 2 * MESH_X * (MESH_Y - 1)
) (
  input  logic [XW-1:0]    srcX,
  input  logic [YW-1:0]    srcY,
  input  logic [XW-1:0]    dstX,
  input  logic [YW-1:0]    dstY,
  output logic [NLINK-1:0] mask,
  output logic [HW-1:0]    hops
);
  localparam int EW_CNT = MESH_Y * (MESH_X - 1);
  localparam int NS_CNT = MESH_X * (MESH_Y - 1);

  logic goEast, goWest, goNorth, goSouth;
  logic [XW-1:0] spanX;
  logic [YW-1:0] spanY;

  always_comb begin
    goEast  = dstX > srcX;
    goWest  = dstX < srcX;
    goNorth = dstY > srcY;
    goSouth = dstY < srcY;
    spanX   = goWest ? (srcX - dstX) : (dstX - srcX);
    spanY   = goSouth ? (srcY - dstY) : (dstY - srcY);
    hops    = HW'(spanX) + HW'(spanY);
  end

  // horizontal links live in the source row
  for (genvar r = 0; r < MESH_Y; r++) begin : gRow
    for (genvar c = 0; c < MESH_X - 1; c++) begin : gCol
      localparam logic [YW-1:0] RY = YW'(r);
      localparam logic [XW-1:0] CX = XW'(c);
      assign mask[r*(MESH_X-1)+c] =
        (srcY == RY) && goEast && (CX >= srcX) && (CX < dstX);
      assign mask[EW_CNT+r*(MESH_X-1)+c] =
        (srcY == RY) && goWest && (CX >= dstX) && (CX < srcX);
    end
  end

  // vertical links live in the target column
  for (genvar c = 0; c < MESH_X; c++) begin : gVcol
    for (genvar r = 0; r < MESH_Y - 1; r++) begin : gVrow
      localparam logic [YW-1:0] RY = YW'(r);
      localparam logic [XW-1:0] CX = XW'(c);
      assign mask[2*EW_CNT+c*(MESH_Y-1)+r] =
        (dstX == CX) && goNorth && (RY >= srcY) && (RY < dstY);
      assign mask[2*EW_CNT+NS_CNT+c*(MESH_Y-1)+r] =
        (dstX == CX) && goSouth && (RY >= dstY) && (RY < srcY);
    end
  end
endmodule

// File: rtl/pathDatapath.sv
module pathDatapath
  import meshPkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int XW = $clog2(MESH_X),
  parameter int YW = $clog2(MESH_Y),
  parameter int HW = $clog2(MESH_X + MESH_Y - 1),
  parameter int NLINK = 2 * MESH_Y * (MESH_X - 1) + 2 * MESH_X * (MESH_Y - 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [XW-1:0] reqSrcX,
  input  logic [YW-1:0] reqSrcY,
  input  logic [XW-1:0] reqDstX,
  input  logic [YW-1:0] reqDstY,
  input  logic          relValid,
  input  logic [XW-1:0] relSrcX,
  input  logic [YW-1:0] relSrcY,
  input  logic [XW-1:0] relDstX,
  input  logic [YW-1:0] relDstY,
  input  ctlStrobe_t    strb,
  output logic          conflict,
  output logic          relMissing,
  output logic [HW-1:0] reqHops
);
  logic [NLINK-1:0] occ, reqMask, relMask, relClr, occAfterRel;
  logic [HW-1:0] relHops;

  xyRouteMask #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW), .HW(HW), .NLINK(NLINK))
    uReqRoute (.srcX(reqSrcX), .srcY(reqSrcY), .dstX(reqDstX), .dstY(reqDstY),
               .mask(reqMask), .hops(reqHops));

  xyRouteMask #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW), .HW(HW), .NLINK(NLINK))
    uRelRoute (.srcX(relSrcX), .srcY(relSrcY), .dstX(relDstX), .dstY(relDstY),
               .mask(relMask), .hops(relHops));

  always_comb begin
    relClr      = relValid ? relMask : '0;
    occAfterRel = occ & ~relClr;
    conflict    = |(occAfterRel & reqMask);
    relMissing  = |(relMask & ~occ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else if (strb.doGrant || strb.doRelease)
      occ <= (occ & ~(strb.doRelease ? relMask : '0)) | (strb.doGrant ? reqMask : '0);
  end

  AST_REFUSE_HOLDS_LINKS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.doGrant && !strb.doRelease) |=> $stable(occ)); // R4
  AST_GRANT_MARKS_PATH: assert property (@(posedge clk) disable iff (!rstN)
    strb.doGrant |=> ((occ & $past(reqMask)) == $past(reqMask))); // R3
  AST_GRANT_ON_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doGrant && !relValid) |-> ((occ & reqMask) == '0)); // R4
  AST_RELEASE_FREES_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRelease && !strb.doGrant) |=> ((occ & $past(relMask)) == '0)); // R7
  AST_HOPS_MATCH_LINKS: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(reqMask) == int'(reqHops)) && ($countones(relMask) == int'(relHops))); // R6
  AST_SELF_ROUTE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ((reqSrcX == reqDstX) && (reqSrcY == reqDstY)) |-> (reqMask == '0)); // R5
endmodule

// File: rtl/pathControl.sv
module pathControl
  import meshPkg::*;
#(
  parameter int TAG_W = 16,
  parameter int HW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             relValid,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [HW-1:0]    reqHops,
  input  logic             conflict,
  input  logic             relMissing,
  output ctlStrobe_t       strb,
  output logic             respValid,
  output logic             respGrant,
  output logic [TAG_W-1:0] respTag,
  output logic [HW-1:0]    respHops,
  output logic             relError
);
  always_comb begin
    strb.doRelease = relValid;
    strb.doGrant   = reqValid && !conflict;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respGrant <= 1'b0;
      respTag   <= '0;
      respHops  <= '0;
      relError  <= 1'b0;
    end else begin
      respValid <= reqValid;
      respGrant <= strb.doGrant;
      respTag   <= reqValid ? reqTag : respTag;
      respHops  <= strb.doGrant ? reqHops : '0;
      relError  <= relValid && relMissing;
    end
  end

  AST_REFUSE_ZERO_HOPS: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respGrant) |-> (respHops == '0)); // R4
  AST_GRANT_HAS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    respGrant |-> respValid); // R10
  AST_ERR_FOLLOWS_REL: assert property (@(posedge clk) disable iff (!rstN)
    relError |-> $past(relValid)); // R7
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(reqValid)); // R10
endmodule

// File: rtl/meshPathReserve.sv
module meshPathReserve
  import meshPkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int TAG_W = 16,
  localparam int XW = $clog2(MESH_X),
  localparam int YW = $clog2(MESH_Y),
  localparam int HW = $clog2(MESH_X + MESH_Y - 1),
  localparam int NLINK = 2 * MESH_Y * (MESH_X - 1) + 2 * MESH_X * (MESH_Y - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [XW-1:0]    reqSrcX,
  input  logic [YW-1:0]    reqSrcY,
  input  logic [XW-1:0]    reqDstX,
  input  logic [YW-1:0]    reqDstY,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             relValid,
  input  logic [XW-1:0]    relSrcX,
  input  logic [YW-1:0]    relSrcY,
  input  logic [XW-1:0]    relDstX,
  input  logic [YW-1:0]    relDstY,
  output logic             respValid,
  output logic             respGrant,
  output logic [TAG_W-1:0] respTag,
  output logic [HW-1:0]    respHops,
  output logic             relError
);
  ctlStrobe_t strb;
  logic conflict, relMissing;
  logic [HW-1:0] reqHops;

  pathDatapath #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW), .HW(HW), .NLINK(NLINK))
    uData (.clk(clk), .rstN(rstN),
           .reqSrcX(reqSrcX), .reqSrcY(reqSrcY), .reqDstX(reqDstX), .reqDstY(reqDstY),
           .relValid(relValid),
           .relSrcX(relSrcX), .relSrcY(relSrcY), .relDstX(relDstX), .relDstY(relDstY),
           .strb(strb), .conflict(conflict), .relMissing(relMissing), .reqHops(reqHops));

  pathControl #(.TAG_W(TAG_W), .HW(HW))
    uCtrl (.clk(clk), .rstN(rstN), .reqValid(reqValid), .relValid(relValid),
           .reqTag(reqTag), .reqHops(reqHops), .conflict(conflict), .relMissing(relMissing),
           .strb(strb), .respValid(respValid), .respGrant(respGrant), .respTag(respTag),
           .respHops(respHops), .relError(relError));
endmodule

// File: tb/tb_meshPathReserve.sv
`timescale 1ns/1ps
module tb_meshPathReserve;
  localparam int MX = 8, MY = 8, TW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, reqValid, relValid;
  logic [2:0] reqSrcX, reqSrcY, reqDstX, reqDstY, relSrcX, relSrcY, relDstX, relDstY;
  logic [TW-1:0] reqTag, respTag;
  logic respValid, respGrant, relError;
  logic [3:0] respHops;

  meshPathReserve #(.MESH_X(MX), .MESH_Y(MY), .TAG_W(TW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSrcX(reqSrcX), .reqSrcY(reqSrcY),
    .reqDstX(reqDstX), .reqDstY(reqDstY), .reqTag(reqTag), .relValid(relValid),
    .relSrcX(relSrcX), .relSrcY(relSrcY), .relDstX(relDstX), .relDstY(relDstY),
    .respValid(respValid), .respGrant(respGrant), .respTag(respTag),
    .respHops(respHops), .relError(relError));

  // model links: east[x][y] is (x,y)->(x+1,y); north[x][y] is (x,y)->(x,y+1)
  bit eastL[MX][MY], westL[MX][MY], northL[MX][MY], southL[MX][MY];
  int checks = 0, errors = 0;
  bit finished = 0;
  int lsx[32], lsy[32], ldx[32], ldy[32];
  int nList = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode 0: count busy, 1: set, 2: clear and count missing
  function automatic bit upd(input bit cur, input int mode, inout int cnt);
    if (mode == 0) begin if (cur) cnt++; return cur; end
    if (mode == 1) return 1'b1;
    if (!cur) cnt++;
    return 1'b0;
  endfunction

  task automatic walk(input int sx, input int sy, input int dx, input int dy,
                      input int mode, output int cnt);
    int x = sx;
    int y = sy;
    cnt = 0;
    while (x != dx) begin
      if (dx > x) begin eastL[x][sy] = upd(eastL[x][sy], mode, cnt); x++; end
      else begin westL[x-1][sy] = upd(westL[x-1][sy], mode, cnt); x--; end
    end
    while (y != dy) begin
      if (dy > y) begin northL[dx][y] = upd(northL[dx][y], mode, cnt); y++; end
      else begin southL[dx][y-1] = upd(southL[dx][y-1], mode, cnt); y--; end
    end
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic stepCycle(input bit rq, input int sx, input int sy, input int dx, input int dy,
                           input int tag, input bit rl, input int rsx, input int rsy,
                           input int rdx, input int rdy, input string req, output bit granted);
    int miss, busy, dummy;
    bit expG, expE;
    int expH;
    miss = 0; busy = 0;
    reqValid = rq; reqSrcX = 3'(sx); reqSrcY = 3'(sy); reqDstX = 3'(dx); reqDstY = 3'(dy);
    reqTag = TW'(tag);
    relValid = rl; relSrcX = 3'(rsx); relSrcY = 3'(rsy); relDstX = 3'(rdx); relDstY = 3'(rdy);
    if (rl) walk(rsx, rsy, rdx, rdy, 2, miss);   // release first (R8)
    expE = rl && (miss > 0);
    expG = 0; expH = 0;
    if (rq) begin
      walk(sx, sy, dx, dy, 0, busy);
      expG = (busy == 0);
      if (expG) begin walk(sx, sy, dx, dy, 1, dummy); expH = absd(sx, dx) + absd(sy, dy); end
    end
    @(posedge clk); #1;
    check(respValid == rq, req, "respValid", int'(respValid), int'(rq));
    if (rq) begin
      check(respGrant == expG, req, "respGrant", int'(respGrant), int'(expG));
      check(int'(respHops) == expH, req, "respHops", int'(respHops), expH);
      check(int'(respTag) == tag, req, "respTag", int'(respTag), tag);
    end
    check(relError == expE, req, "relError", int'(relError), int'(expE));
    granted = expG;
    reqValid = 0; relValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WATCHDOG", "timeout", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g;
    void'($urandom(32'd4242));
    rstN = 0; reqValid = 0; relValid = 0; reqTag = '0;
    {reqSrcX, reqSrcY, reqDstX, reqDstY, relSrcX, relSrcY, relDstX, relDstY} = '0;
    repeat (3) @(posedge clk); #1;
    rstN = 1;
    check(respValid == 0, "R1", "respValid after reset", int'(respValid), 0);
    check(relError == 0, "R1", "relError after reset", int'(relError), 0);
    // R1/R6: longest path is free, 14 hops
    stepCycle(1, 0,0, 7,7, 11, 0, 0,0,0,0, "R1", g);
    stepCycle(0, 0,0,0,0, 0, 1, 0,0, 7,7, "R7", g);      // clean release
    stepCycle(0, 0,0,0,0, 0, 1, 0,0, 7,7, "R7", g);      // repeat -> error
    // R5: self route
    stepCycle(1, 3,3, 3,3, 22, 0, 0,0,0,0, "R5", g);
    // R9: opposite directions on the same row
    stepCycle(1, 1,2, 5,2, 33, 0, 0,0,0,0, "R9", g);
    stepCycle(1, 5,2, 1,2, 34, 0, 0,0,0,0, "R9", g);
    // R4: refusal reserves nothing; link (0,2)->(1,2) stays free
    stepCycle(1, 0,2, 3,5, 44, 0, 0,0,0,0, "R4", g);
    stepCycle(1, 0,2, 1,0, 45, 0, 0,0,0,0, "R4", g);
    // R2: X first, then Y
    stepCycle(1, 0,0, 3,0, 55, 0, 0,0,0,0, "R2", g);
    stepCycle(1, 0,1, 2,0, 56, 0, 0,0,0,0, "R2", g);     // Y-first would collide
    stepCycle(1, 0,0, 2,2, 57, 0, 0,0,0,0, "R2", g);     // uses busy row-0 links
    // R8: release in the same cycle frees the row-0 links
    stepCycle(1, 0,0, 2,2, 66, 1, 0,0, 3,0, "R8", g);
    // R10: random traffic
    for (int i = 0; i < 4000; i++) begin
      int sx, sy, dx, dy, rsx, rsy, rdx, rdy, k;
      bit rq, rl;
      rq = ($urandom % 100) < 80;
      sx = $urandom % MX; sy = $urandom % MY; dx = $urandom % MX; dy = $urandom % MY;
      rl = 0; k = -1; rsx = 0; rsy = 0; rdx = 0; rdy = 0;
      if (nList > 0 && ($urandom % 100) < 45) begin
        k = $urandom % nList; rl = 1;
        rsx = lsx[k]; rsy = lsy[k]; rdx = ldx[k]; rdy = ldy[k];
        nList--;
        lsx[k] = lsx[nList]; lsy[k] = lsy[nList]; ldx[k] = ldx[nList]; ldy[k] = ldy[nList];
      end else if (($urandom % 100) < 5) begin
        rl = 1; rsx = $urandom % MX; rsy = $urandom % MY; rdx = $urandom % MX; rdy = $urandom % MY;
      end
      stepCycle(rq, sx, sy, dx, dy, i & 16'hffff, rl, rsx, rsy, rdx, rdy, "R10", g);
      if (g && nList < 32) begin
        lsx[nList] = sx; lsy[nList] = sy; ldx[nList] = dx; ldy[nList] = dy; nList++;
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule